// File: doc/BRIEF.md
# Packed Integer Unpack Unit

The unit widens packed small integers into full 32-bit words. One or two source words arrive on a valid/ready input beat together with a 2-bit operation code and a source-size code. Every 8-bit or 16-bit lane is placed at the top of its own result word. The block returns two or four result words on a valid/ready output beat, together with a count of how many of them are meaningful.

The two unsigned forms do not simply zero-extend. A 16-bit unsigned lane ends up one bit lower than the signed form. An 8-bit unsigned lane is first copied into all four byte positions of the word and then shifted right by one bit. A 16-bit request whose size code is neither one word nor two words returns an error beat that carries no results.

The unit has one register stage. An accepted beat appears on the output on the next clock. The input is ready whenever the output register is empty or is being drained in the same cycle. While the consumer holds `out_ready` low, the pending result stays frozen and no new beat is taken.

Top module: `pkunpack_unit`

## Requirements
- R1: Bit 1 of `op` picks the lane width (0 = 8-bit lanes, 1 = 16-bit lanes). Bit 0 picks the form (0 = unsigned, 1 = signed).
- R2: In signed 16-bit mode, a source word S gives result 0 = S shifted left by 16 bits, and result 1 = S with bits 15..0 cleared.
- R3: In unsigned 16-bit mode, both results of R2 are also shifted right by one bit, so each lane occupies bits 30..15 and bit 31 is zero.
- R4: In 16-bit mode, size code 0 (one word) gives 2 results from `src0`. Size code 1 (two words) gives 4 results, and `src1` fills results 2 and 3.
- R5: In 8-bit mode, `src0` always gives 4 results. For k = 0 (least significant byte) to 3, byte k goes to bits 31..24 of result k and all other bits are zero (signed form). `size` and `src1` have no effect.
- R6: In unsigned 8-bit mode, each R5 result v becomes ((v | v>>8) | (v | v>>8)>>16) >> 1. For a byte b this is {0, b, b, b, b[7:1]}.
- R7: In 16-bit mode, size codes 2 and 3 are illegal. The beat then has `err` = 1, `res_count` = 0 and all results zero. Legal beats have `err` = 0.
- R8: `res_count` is 2 or 4 on legal beats, and result words at positions at or above the count are zero.
- R9: A beat accepted on a clock edge (`in_valid` and `in_ready`) is presented with `out_valid` = 1 right after that edge. With nothing accepted and the output drained, `out_valid` falls.
- R10: `in_ready` = 1 exactly when the output is empty or `out_ready` is 1. While `out_valid` = 1 and `out_ready` = 0, the output data, count and error flag hold.
- R11: Synchronous active-high `rst` clears `out_valid`, all results, `res_count` and `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| op | input | 2 | Operation: bit 1 width, bit 0 signed form |
| size | input | 2 | Source size: 0 one word, 1 two words, 2/3 illegal in 16-bit mode |
| src0 | input | 32 | First source word |
| src1 | input | 32 | Second source word |
| out_valid | output | 1 | Result beat present (done strobe) |
| out_ready | input | 1 | Consumer takes the result beat |
| res_data | output | 128 | Result word i at bits [32*i+31 : 32*i] |
| res_count | output | 3 | Number of meaningful results (0, 2 or 4) |
| err | output | 1 | Illegal size on this beat |

## Verification
Two things can coincide on one clock edge: a held result leaving the output register and a fresh beat loading into it. The main sweep drives a new beat on every cycle with `out_ready` high, so each edge both drains and refills the stage. Every output is then compared with the value computed for the preceding beat, which catches a lost or duplicated beat. A second case stalls the output and offers a new beat at the same time. There the frozen result and the low `in_ready` are checked, and then the second beat must appear unchanged once the stall is released.

// File: rtl/pku_pkg.sv
package pku_pkg;
  localparam int WORD_W  = 32;
  localparam int NUM_SRC = 2;
  localparam int NUM_RES = 4;
  localparam int CNT_W   = $clog2(NUM_RES + 1);

  typedef enum logic [1:0] {
    SZ_ONE  = 2'b00,
    SZ_TWO  = 2'b01,
    SZ_BAD2 = 2'b10,
    SZ_BAD3 = 2'b11
  } src_size_e;

  function automatic logic op_is_wide(input logic [1:0] code);
    return code[1];
  endfunction

  function automatic logic op_is_unsigned(input logic [1:0] code);
    return ~code[0];
  endfunction
endpackage

// File: rtl/pku_lane16.sv
module pku_lane16 #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] src,
  input  logic              uns,
  output logic [WORD_W-1:0] r_lo,
  output logic [WORD_W-1:0] r_hi
);
  localparam int HALF = WORD_W / 2;

  logic [WORD_W-1:0] lo_top, hi_top;

  always_comb begin
    lo_top = {src[HALF-1:0], {HALF{1'b0}}};
    hi_top = {src[WORD_W-1:HALF], {HALF{1'b0}}};
    r_lo   = uns ? (lo_top >> 1) : lo_top;
    r_hi   = uns ? (hi_top >> 1) : hi_top;
  end
endmodule

// File: rtl/pku_lane8.sv
module pku_lane8 #(
  parameter int WORD_W = 32,
  parameter int LANES  = WORD_W / 8
) (
  input  logic [WORD_W-1:0]             src,
  input  logic                          uns,
  output logic [LANES-1:0][WORD_W-1:0]  res
);
  localparam int LANE_W = WORD_W / LANES;

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    logic [LANE_W-1:0] b;
    logic [WORD_W-1:0] placed, spread;
    always_comb begin
      b      = src[k*LANE_W +: LANE_W];
      placed = {b, {(WORD_W-LANE_W){1'b0}}};
      spread = {LANES{b}};
      res[k] = uns ? (spread >> 1) : placed;
    end
  end
endmodule

// File: rtl/pku_select.sv
module pku_select
  import pku_pkg::*;
(
  input  logic [1:0]                       op,
  input  logic [1:0]                       size,
  input  logic [NUM_SRC-1:0][WORD_W-1:0]   src,
  output logic [NUM_RES-1:0][WORD_W-1:0]   res,
  output logic [CNT_W-1:0]                 cnt,
  output logic                             err
);
  logic                               uns;
  logic [NUM_RES-1:0][WORD_W-1:0]     wide_res;
  logic [NUM_RES-1:0][WORD_W-1:0]     narrow_res;

  assign uns = op_is_unsigned(op);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_wide
    pku_lane16 #(.WORD_W(WORD_W)) u_l16 (
      .src  (src[s]),
      .uns  (uns),
      .r_lo (wide_res[2*s]),
      .r_hi (wide_res[2*s+1])
    );
  end

  pku_lane8 #(.WORD_W(WORD_W), .LANES(NUM_RES)) u_l8 (
    .src (src[0]),
    .uns (uns),
    .res (narrow_res)
  );

  always_comb begin
    res = '0;
    cnt = '0;
    err = 1'b0;
    if (!op_is_wide(op)) begin
      res = narrow_res;
      cnt = CNT_W'(NUM_RES);
    end else begin
      unique case (src_size_e'(size))
        SZ_ONE: begin
          res[0] = wide_res[0];
          res[1] = wide_res[1];
          cnt    = CNT_W'(2);
        end
        SZ_TWO: begin
          res = wide_res;
          cnt = CNT_W'(NUM_RES);
        end
        default: err = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/pku_outreg.sv
module pku_outreg
  import pku_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [NUM_RES-1:0][WORD_W-1:0]  d_res,
  input  logic [CNT_W-1:0]                d_cnt,
  input  logic                            d_err,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [NUM_RES-1:0][WORD_W-1:0]  q_res,
  output logic [CNT_W-1:0]                q_cnt,
  output logic                            q_err
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      q_res     <= '0;
      q_cnt     <= '0;
      q_err     <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      q_res     <= d_res;
      q_cnt     <= d_cnt;
      q_err     <= d_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_accept_done_R9: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);
  assert_drain_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && out_ready) |=> !out_valid);
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(q_res) && $stable(q_cnt) && $stable(q_err)));
  assert_err_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && q_err) |-> (q_cnt == '0 && q_res == '0));
  assert_count_legal_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !q_err) |-> (q_cnt == CNT_W'(2) || q_cnt == CNT_W'(NUM_RES)));
  assert_tail_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && q_cnt == CNT_W'(2)) |-> (q_res[NUM_RES-1:2] == '0));
  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (!out_valid && !q_err && q_cnt == '0));
endmodule

// File: rtl/pkunpack_unit.sv
module pkunpack_unit
  import pku_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [1:0]                 op,
  input  logic [1:0]                 size,
  input  logic [WORD_W-1:0]          src0,
  input  logic [WORD_W-1:0]          src1,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [NUM_RES*WORD_W-1:0]  res_data,
  output logic [CNT_W-1:0]           res_count,
  output logic                       err
);
  logic [NUM_SRC-1:0][WORD_W-1:0] src_vec;
  logic [NUM_RES-1:0][WORD_W-1:0] nxt_res, q_res;
  logic [CNT_W-1:0]               nxt_cnt;
  logic                           nxt_err;

  assign src_vec = {src1, src0};

  pku_select u_sel (
    .op   (op),
    .size (size),
    .src  (src_vec),
    .res  (nxt_res),
    .cnt  (nxt_cnt),
    .err  (nxt_err)
  );

  pku_outreg u_reg (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_res     (nxt_res),
    .d_cnt     (nxt_cnt),
    .d_err     (nxt_err),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q_res     (q_res),
    .q_cnt     (res_count),
    .q_err     (err)
  );

  assign res_data = q_res;
endmodule

// File: tb/pkunpack_unit_tb.sv
module pkunpack_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   op = '0;
  logic [1:0]   size = '0;
  logic [31:0]  src0 = '0;
  logic [31:0]  src1 = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] res_data;
  logic [2:0]   res_count;
  logic         err;

  int n_checks = 0;
  int n_fail   = 0;
  logic [127:0] exp_data;
  logic [2:0]   exp_cnt;
  logic         exp_err;
  logic         have_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkunpack_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .size(size), .src0(src0), .src1(src1),
    .out_valid(out_valid), .out_ready(out_ready),
    .res_data(res_data), .res_count(res_count), .err(err)
  );

  task automatic model(input logic [1:0] o, input logic [1:0] s,
                       input logic [31:0] a, input logic [31:0] b);
    logic [31:0] w [4];
    for (int i = 0; i < 4; i++) w[i] = '0;
    exp_err = 1'b0;
    exp_cnt = 3'd0;
    if (o[1]) begin
      if (s[1]) begin
        exp_err = 1'b1;
      end else begin
        w[0] = a << 16;
        w[1] = a & 32'hFFFF_0000;
        exp_cnt = 3'd2;
        if (s == 2'b01) begin
          w[2] = b << 16;
          w[3] = b & 32'hFFFF_0000;
          exp_cnt = 3'd4;
        end
        if (!o[0]) for (int i = 0; i < 4; i++) w[i] = w[i] >> 1;
      end
    end else begin
      exp_cnt = 3'd4;
      for (int k = 0; k < 4; k++) begin
        logic [7:0] by;
        by = a[8*k +: 8];
        if (o[0]) w[k] = {by, 24'h0};
        else      w[k] = {1'b0, by, by, by, by[7:1]};
      end
    end
    exp_data = {w[3], w[2], w[1], w[0]};
  endtask

  task automatic check_out(input string tag);
    n_checks++;
    if (out_valid !== 1'b1 || res_data !== exp_data || res_count !== exp_cnt || err !== exp_err) begin
      n_fail++;
      $display("FAIL %s: got v=%0b d=%h c=%0d e=%0b exp v=1 d=%h c=%0d e=%0b",
               tag, out_valid, res_data, res_count, err, exp_data, exp_cnt, exp_err);
    end
  endtask

  task automatic check_bit(input string tag, input logic got, input logic want);
    n_checks++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: got %0b exp %0b", tag, got, want);
    end
  endtask

  // Drive one beat per cycle; the output of the previous beat is checked
  // in the same cycle, so drain and refill coincide (R9, R10).
  task automatic push(input logic [1:0] o, input logic [1:0] s,
                      input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    if (have_prev) check_out("R1 R2 R3 R4 R5 R6 R7 R8 stream");
    in_valid = 1'b1; op = o; size = s; src0 = a; src1 = b;
    model(o, s, a, b);
    have_prev = 1'b1;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    logic [31:0] seed;
    logic [31:0] pats [8];
    seed = 32'h1234_5678;
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h8000_8000; pats[3] = 32'h7F7F_7F7F;
    pats[4] = 32'h0102_0304; pats[5] = 32'h80FF_0100;
    pats[6] = 32'h0001_FFFE; pats[7] = 32'hA55A_C33C;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check_bit("R11 out_valid", out_valid, 1'b0);
    check_bit("R11 err", err, 1'b0);
    check_bit("R11 count zero", res_count == 3'd0, 1'b1);
    check_bit("R11 data zero", res_data == '0, 1'b1);
    check_bit("R10 ready when empty", in_ready, 1'b1);

    // Sweep every op and size code over corner and pseudo-random words.
    for (int o = 0; o < 4; o++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 40; p++) begin
          logic [31:0] a, b;
          if (p < 8) begin
            a = pats[p]; b = pats[7-p];
          end else begin
            seed = seed * 32'd1664525 + 32'd1013904223; a = seed;
            seed = seed * 32'd1664525 + 32'd1013904223; b = seed;
          end
          push(o[1:0], s[1:0], a, b);
        end
    @(negedge clk);
    check_out("R4 last stream beat");
    in_valid = 1'b0;
    have_prev = 1'b0;
    @(negedge clk);
    check_bit("R9 falls when idle", out_valid, 1'b0);

    // R10: stall with a new beat offered at the same time.
    out_ready = 1'b0;
    in_valid = 1'b1; op = 2'b11; size = 2'b01; src0 = 32'h1122_3344; src1 = 32'h5566_7788;
    model(op, size, src0, src1);
    @(negedge clk);
    check_out("R9 done after accept");
    in_valid = 1'b1; op = 2'b00; size = 2'b10; src0 = 32'hC0DE_F00D; src1 = 32'h0;
    #1;
    check_bit("R10 not ready on stall", in_ready, 1'b0);
    @(negedge clk);
    check_out("R10 held under stall");
    @(negedge clk);
    check_out("R10 still held");
    out_ready = 1'b1;
    #1;
    check_bit("R10 ready when draining", in_ready, 1'b1);
    model(2'b00, 2'b10, 32'hC0DE_F00D, 32'h0);
    @(negedge clk);
    check_out("R5 R6 beat after stall");
    in_valid = 1'b0;
    @(negedge clk);
    check_bit("R9 empty after drain", out_valid, 1'b0);

    // R7 then R11: an error beat, then a reset while it is held.
    out_ready = 1'b0;
    in_valid = 1'b1; op = 2'b10; size = 2'b11; src0 = 32'hFFFF_FFFF; src1 = 32'hFFFF_FFFF;
    model(op, size, src0, src1);
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R7 illegal size");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_bit("R11 clears valid", out_valid, 1'b0);
    check_bit("R11 clears err", err, 1'b0);
    check_bit("R11 clears data", (res_data == '0) && (res_count == 3'd0), 1'b1);
    out_ready = 1'b1;

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule